// File: doc/BRIEF.md
# Serial NOR Flash Target

This block behaves like a serial NOR flash memory as seen from an SPI host. The host uses chip select, serial clock and one data line in each direction, and every byte travels most significant bit first. Inside is a small byte array whose size is a parameter. Reset fills the array with the erased value 0xFF. An opcode-driven state machine assembles bytes from the host. It streams read data, programs bytes within a page, and erases aligned regions or the whole array. Program and erase take effect at once, so the part never reports busy.

The serial inputs are sampled on the block's own system clock, which must run several times faster than the serial clock. MOSI is captured on the rising serial-clock edge and MISO moves on the falling edge (SPI mode 0). The reply to each byte is shifted out during the following byte. The first byte of every selection therefore reads back as 0xFF.

Top module: `spi_nor_target`

## Requirements
- R1: After reset every array byte reads 0xFF. MISO is 1 while chip select is high, and on deselection the command state machine returns to idle.
- R2: Opcode 0x9F returns three bytes on the three bytes that follow it: manufacturer (default 0x20), memory type (default 0x20), and a capacity code equal to log2 of the array size (0x0B for the default 2048 bytes). Later bytes read 0xFF.
- R3: Opcode 0x05 returns 0x00 on the next byte and 0xFF after that.
- R4: MISO changes only after a falling serial-clock edge. The reply to byte N is sent MSB first during byte N+1, and the opcode byte itself reads 0xFF.
- R5: Opcode 0x03 takes a 24-bit address, most significant byte first. Data starts on the byte after the address and the address increments every byte. The address is taken modulo the array size, so reading past the last byte continues at address 0.
- R6: Opcode 0x0B takes the same address and then one dummy byte, which reads 0xFF. Data starts on the byte after the dummy.
- R7: Opcode 0x06 sets the write-enable latch, and a deselection keeps it when 0x06 was the last opcode. Any further byte clocked in the same selection clears it.
- R8: Opcode 0x04 clears the latch. A deselection clears it whenever the last opcode was not 0x06.
- R9: Opcode 0x02 takes an address and then writes each data byte only while the latch is set. The address advances within a 256-byte page and wraps to the start of that page.
- R10: Opcode 0x20 sets the aligned 256-byte sub-sector that holds the address to 0xFF. Opcode 0xD8 does the same for the aligned 1024-byte sector. Either acts only while the latch is set.
- R11: Opcode 0xC7 sets the whole array to 0xFF, and only while the latch is set.
- R12: Any other opcode is ignored. Every byte up to deselection reads 0xFF and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idles low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume the host's pins are synchronous to the system clock. They also assume each serial-clock phase lasts several system cycles and chip select changes only while the serial clock is low. Under those conditions one sampled edge matches one serial edge, and MISO can be checked for stability between falling edges. The bench changes its pins only on the falling system-clock edge, holds each serial-clock phase for four system cycles, and keeps the serial clock low around every chip-select change.

// File: rtl/spi_nor_target.sv
module spi_nor_target #(
  parameter int          MEM_BYTES  = 2048,
  parameter int          PAGE_BYTES = 256,
  parameter int          SUB_BYTES  = 256,
  parameter int          SECT_BYTES = 1024,
  parameter logic [7:0]  ID_MANUF   = 8'h20,
  parameter logic [7:0]  ID_TYPE    = 8'h20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam int SUBW = $clog2(SUB_BYTES);
  localparam int SECW = $clog2(SECT_BYTES);
  localparam logic [7:0] ID_CAP = 8'(AW);

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_ID   = 8'h9F;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_FRD  = 8'h0B;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SER  = 8'hD8;
  localparam logic [7:0] OP_SSER = 8'h20;
  localparam logic [7:0] OP_BER  = 8'hC7;

  typedef enum logic [3:0] {
    S_IDLE, S_ID1, S_ID2, S_WEN, S_SKIP, S_A1, S_A2, S_A3, S_DUMMY, S_RDAT, S_PDAT
  } st_t;

  st_t         st, st_n;
  logic [2:0]  bcnt;
  logic [6:0]  shr;
  logic        sck_q;
  logic [7:0]  tx, resp, resp_n, lop, lop_n;
  logic [23:0] addr, addr_n;
  logic        wel, wel_n;
  logic        do_pgm, do_sub, do_sec, do_all;
  logic [AW-1:0] wa;
  logic [7:0]  mem [MEM_BYTES];

  wire       sck_rise  = sck & ~sck_q;
  wire       sck_fall  = ~sck & sck_q;
  wire       byte_done = ~cs_n & sck_rise & (bcnt == 3'd7);
  wire [7:0] rx        = {shr, mosi};

  assign miso = cs_n ? 1'b1 : tx[7];

  always_comb begin
    st_n   = st;
    addr_n = addr;
    wel_n  = wel;
    resp_n = resp;
    lop_n  = lop;
    do_pgm = 1'b0;
    do_sub = 1'b0;
    do_sec = 1'b0;
    do_all = 1'b0;
    wa     = addr[AW-1:0];
    if (byte_done) begin
      resp_n = 8'hFF;
      case (st)
        S_IDLE: begin
          lop_n = rx;
          st_n  = S_SKIP;
          case (rx)
            OP_ID:   begin resp_n = ID_MANUF; st_n = S_ID1; end
            OP_WEN:  begin wel_n = 1'b1; st_n = S_WEN; end
            OP_WDIS: wel_n = 1'b0;
            OP_STAT: resp_n = 8'h00;
            OP_BER:  do_all = wel;
            OP_RD, OP_FRD, OP_PROG, OP_SER, OP_SSER: st_n = S_A1;
            default: ;
          endcase
        end
        S_ID1: begin resp_n = ID_TYPE; st_n = S_ID2; end
        S_ID2: begin resp_n = ID_CAP;  st_n = S_SKIP; end
        S_WEN: wel_n = 1'b0;
        S_A1:  begin addr_n = {rx, addr[15:0]}; st_n = S_A2; end
        S_A2:  begin addr_n = {addr[23:16], rx, addr[7:0]}; st_n = S_A3; end
        S_A3: begin
          addr_n = {addr[23:8], rx};
          wa     = addr_n[AW-1:0];
          st_n   = S_SKIP;
          case (lop)
            OP_SER:  do_sec = wel;
            OP_SSER: do_sub = wel;
            OP_PROG: st_n = S_PDAT;
            OP_FRD:  st_n = S_DUMMY;
            default: begin
              resp_n = mem[wa];
              addr_n = addr_n + 24'd1;
              st_n   = S_RDAT;
            end
          endcase
        end
        S_DUMMY, S_RDAT: begin
          resp_n = mem[addr[AW-1:0]];
          addr_n = addr + 24'd1;
          st_n   = S_RDAT;
        end
        S_PDAT: begin
          do_pgm = wel;
          addr_n = {addr[23:PW], addr[PW-1:0] + PW'(1)};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      st    <= S_IDLE;
      bcnt  <= 3'd0;
      shr   <= 7'd0;
      tx    <= 8'hFF;
      resp  <= 8'hFF;
      lop   <= 8'hFF;
      addr  <= 24'd0;
      wel   <= 1'b0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        st   <= S_IDLE;
        bcnt <= 3'd0;
        tx   <= 8'hFF;
        resp <= 8'hFF;
        if (lop != OP_WEN) wel <= 1'b0;
      end else begin
        if (sck_rise) begin
          bcnt <= bcnt + 3'd1;
          shr  <= {shr[5:0], mosi};
        end
        if (byte_done) begin
          st   <= st_n;
          addr <= addr_n;
          wel  <= wel_n;
          resp <= resp_n;
          lop  <= lop_n;
        end
        if (sck_fall) tx <= (bcnt == 3'd0) ? resp : {tx[6:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        if (do_all ||
            (do_sec && ((AW'(i) >> SECW) == (wa >> SECW))) ||
            (do_sub && ((AW'(i) >> SUBW) == (wa >> SUBW))))
          mem[i] <= 8'hFF;
        else if (do_pgm && (AW'(i) == wa))
          mem[i] <= rx;
      end
    end
  end
endmodule

// File: rtl/spi_nor_target_chk.sv
module spi_nor_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        miso,
  input logic        wel,
  input logic [7:0]  lop,
  input logic        st_idle,
  input logic        in_prog,
  input logic        byte_done,
  input logic [23:0] addr_page
);
  logic sck_d, seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      seen  <= 1'b0;
    end else begin
      sck_d <= sck;
      seen  <= 1'b1;
    end
  end
  wire fall = ~sck & sck_d;

  // R1
  desel_miso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> miso);

  // R1
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> st_idle);

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !cs_n && !$past(cs_n) && !$past(fall)) |-> $stable(miso));

  // R7
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> (lop == 8'h06));

  // R8
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && lop != 8'h06) |=> !wel);

  // R9
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_prog && byte_done) |=> (addr_page == $past(addr_page)));
endmodule

bind spi_nor_target spi_nor_target_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .miso      (miso),
  .wel       (wel),
  .lop       (lop),
  .st_idle   (st == S_IDLE),
  .in_prog   (st == S_PDAT),
  .byte_done (byte_done),
  .addr_page (addr >> PW)
);

// File: tb/spi_nor_target_tb.sv
module spi_nor_target_tb;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int   n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_nor_target u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = d[i];
      repeat (3) @(negedge clk);
      q[i] = miso;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel;
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q;
    sel; xfer(op, q); desel;
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] q;
    xfer(a[23:16], q); xfer(a[15:8], q); xfer(a[7:0], q);
  endtask

  task automatic prog(input logic [23:0] a, input int n, input logic [7:0] d0, d1, d2, d3);
    logic [7:0] q;
    sel; xfer(8'h02, q); send_addr(a);
    if (n > 0) xfer(d0, q);
    if (n > 1) xfer(d1, q);
    if (n > 2) xfer(d2, q);
    if (n > 3) xfer(d3, q);
    desel;
  endtask

  task automatic rd(input logic [23:0] a, output logic [7:0] v);
    logic [7:0] q;
    sel; xfer(8'h03, q); send_addr(a); xfer(8'hFF, v); desel;
  endtask

  task automatic erase(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] q;
    sel; xfer(op, q); send_addr(a); desel;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 miso deselected", {7'd0, miso}, 8'h01);
    rd(24'h000000, v); check("R1 erased at 0x000", v, 8'hFF);
    rd(24'h0007FF, v); check("R1 erased at 0x7FF", v, 8'hFF);
  endtask

  task automatic t_ident;
    logic [7:0] q;
    sel;
    xfer(8'h9F, q); check("R4 opcode byte reads FF", q, 8'hFF);
    xfer(8'h00, q); check("R2 manufacturer", q, 8'h20);
    xfer(8'h00, q); check("R2 memory type", q, 8'h20);
    xfer(8'h00, q); check("R2 R4 capacity code msb first", q, 8'h0B);
    xfer(8'h00, q); check("R2 after id", q, 8'hFF);
    desel;
  endtask

  task automatic t_status;
    logic [7:0] q;
    sel;
    xfer(8'h05, q);
    xfer(8'hFF, q); check("R3 status", q, 8'h00);
    xfer(8'hFF, q); check("R3 after status", q, 8'hFF);
    desel;
  endtask

  task automatic t_prog;
    logic [7:0] v, q;
    prog(24'h000010, 1, 8'hAA, 0, 0, 0);
    rd(24'h000010, v); check("R9 no program without latch", v, 8'hFF);
    cmd1(8'h06);
    prog(24'h000010, 3, 8'h11, 8'h22, 8'h33, 0);
    sel; xfer(8'h03, q); send_addr(24'h000010);
    xfer(8'hFF, q); check("R5 R9 read 0x10", q, 8'h11);
    xfer(8'hFF, q); check("R5 read 0x11", q, 8'h22);
    xfer(8'hFF, q); check("R5 read 0x12", q, 8'h33);
    desel;
  endtask

  task automatic t_latch;
    logic [7:0] v, q;
    prog(24'h000020, 1, 8'h55, 0, 0, 0);
    rd(24'h000020, v); check("R8 latch dropped after program", v, 8'hFF);
    sel; xfer(8'h06, q); xfer(8'h00, q); desel;
    prog(24'h000030, 1, 8'hAB, 0, 0, 0);
    rd(24'h000030, v); check("R7 extra byte cancels latch", v, 8'hFF);
    cmd1(8'h06); sel; desel;
    prog(24'h000031, 1, 8'hCD, 0, 0, 0);
    rd(24'h000031, v); check("R7 latch kept over deselect", v, 8'hCD);
    cmd1(8'h06); cmd1(8'h04);
    prog(24'h000032, 1, 8'hEE, 0, 0, 0);
    rd(24'h000032, v); check("R8 write disable", v, 8'hFF);
    cmd1(8'h06); cmd1(8'h05);
    prog(24'h000033, 1, 8'hEF, 0, 0, 0);
    rd(24'h000033, v); check("R8 other opcode drops latch", v, 8'hFF);
  endtask

  task automatic t_page;
    logic [7:0] v;
    cmd1(8'h06);
    prog(24'h0001FE, 4, 8'hA0, 8'hA1, 8'hA2, 8'hA3);
    rd(24'h0001FE, v); check("R9 page 0x1FE", v, 8'hA0);
    rd(24'h0001FF, v); check("R9 page 0x1FF", v, 8'hA1);
    rd(24'h000100, v); check("R9 page wrap 0x100", v, 8'hA2);
    rd(24'h000101, v); check("R9 page wrap 0x101", v, 8'hA3);
    rd(24'h000200, v); check("R9 next page untouched", v, 8'hFF);
  endtask

  task automatic t_rdwrap;
    logic [7:0] v, q;
    cmd1(8'h06); prog(24'h0007FF, 1, 8'h5A, 0, 0, 0);
    cmd1(8'h06); prog(24'h000000, 1, 8'hC3, 0, 0, 0);
    sel; xfer(8'h03, q); send_addr(24'h0007FF);
    xfer(8'hFF, q); check("R5 last byte", q, 8'h5A);
    xfer(8'hFF, q); check("R5 wrap to zero", q, 8'hC3);
    desel;
    rd(24'h0107FF, v); check("R5 address modulo size", v, 8'h5A);
  endtask

  task automatic t_fast;
    logic [7:0] q;
    sel; xfer(8'h0B, q); send_addr(24'h000010);
    xfer(8'h00, q); check("R6 dummy reads FF", q, 8'hFF);
    xfer(8'h00, q); check("R6 first data", q, 8'h11);
    xfer(8'h00, q); check("R6 second data", q, 8'h22);
    desel;
  endtask

  task automatic t_unknown;
    logic [7:0] q, v;
    cmd1(8'h06);
    sel;
    xfer(8'h77, q);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h02, q); check("R12 unknown opcode reads FF", q, 8'hFF);
    end
    desel;
    rd(24'h000010, v); check("R12 array unchanged", v, 8'h11);
    rd(24'h000202, v); check("R12 no program", v, 8'hFF);
  endtask

  task automatic t_erase;
    logic [7:0] v;
    erase(8'h20, 24'h000180);
    rd(24'h000100, v); check("R10 sub erase needs latch", v, 8'hA2);
    cmd1(8'h06); erase(8'h20, 24'h000180);
    rd(24'h000100, v); check("R10 sub erase low edge", v, 8'hFF);
    rd(24'h0001FF, v); check("R10 sub erase high edge", v, 8'hFF);
    rd(24'h000010, v); check("R10 sub erase outside", v, 8'h11);
    cmd1(8'h06); prog(24'h0003FF, 1, 8'h33, 0, 0, 0);
    cmd1(8'h06); prog(24'h000400, 1, 8'h44, 0, 0, 0);
    erase(8'hD8, 24'h000455);
    rd(24'h000400, v); check("R10 sector erase needs latch", v, 8'h44);
    cmd1(8'h06); erase(8'hD8, 24'h000455);
    rd(24'h000400, v); check("R10 sector low edge", v, 8'hFF);
    rd(24'h0007FF, v); check("R10 sector high edge", v, 8'hFF);
    rd(24'h0003FF, v); check("R10 sector outside", v, 8'h33);
  endtask

  task automatic t_bulk;
    logic [7:0] v;
    cmd1(8'hC7);
    rd(24'h000010, v); check("R11 bulk needs latch", v, 8'h11);
    cmd1(8'h06); cmd1(8'hC7);
    rd(24'h000010, v); check("R11 bulk clears 0x010", v, 8'hFF);
    rd(24'h0003FF, v); check("R11 bulk clears 0x3FF", v, 8'hFF);
    rd(24'h000000, v); check("R11 bulk clears 0x000", v, 8'hFF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset; t_ident; t_status; t_prog; t_latch; t_page;
    t_rdwrap; t_fast; t_unknown; t_erase; t_bulk;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule